// File: doc/BRIEF.md
# USB Low-Speed Suspend and Resume Controller

This block looks after the power-saving side of a low-speed (1.5 Mb/s) USB device. It watches the sampled D+ and D- levels for the keep-alive pulses that the host sends once per frame. When these pulses stop for longer than a set number of milliseconds, it puts the device into suspend. Suspend is shown to firmware as a status bit, and an interrupt flag is raised beside it. A dedicated output follows the status bit and puts the transceiver into its low-power state. While the device is suspended, a J-to-K change from the host raises a wake output at once. The wake output is combinational on the line inputs, so it works even when the processor clocks are stopped.

Firmware leaves suspend by clearing the status bit. The block never clears that bit on its own. The one exception is a bus reset, which clears suspend in hardware. Firmware can also wake the host. To do so it sets a send-resume bit, and the block drives K on the data lines for as long as that bit stays set. When firmware clears the bit, the block finishes with an end-of-packet and then releases the output enable.

Top module: `usb_susp_ctl`

## Requirements
- R1: The line encodings are: J is D+ low with D- high, K is D+ high with D- low, and SE0 is both lines low. The suspend bit (register 0, bit 0) sets when no keep-alive has been seen for more than IDLE_MS milliseconds, and at most IDLE_MS+1 milliseconds after the last keep-alive. The idle count advances only while the block is not suspended.
- R2: A keep-alive is an SE0 lasting at least 2 bit times (2*CLK_PER_BIT clocks) followed by J. It restarts the idle time. An SE0 that is shorter does not restart it.
- R3: Entering suspend sets the interrupt flag (register 1, bit 0), and irq_o follows that flag. Writing 1 to the flag clears it. Writing 0 to it has no effect.
- R4: xcvr_susp_o always equals the suspend bit.
- R5: Only two things clear the suspend bit: a firmware write to register 0 with bit 0 equal to 0, or a bus reset. Writing 1 to that bit while the block is not suspended leaves it 0.
- R6: While suspended, wake_o rises as soon as the line goes from J to K, without waiting for a clock edge. It stays high until the suspend bit clears. A K on the line while not suspended leaves wake_o low.
- R7: Setting the send-resume bit (register 0, bit 1) raises tx_oe_o. The block then drives J for one bit time, and after that drives K for as long as the bit stays set.
- R8: After the send-resume bit clears, the block drives SE0 for 2 bit times, then J for 1 bit time, and then drops tx_oe_o.
- R9: An SE0 lasting more than RESET_CLKS clocks is a bus reset. It clears the suspend bit, the send-resume bit and the idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| rx_dp_i | input | 1 | Sampled D+ level |
| rx_dm_i | input | 1 | Sampled D- level |
| tx_dp_o | output | 1 | D+ drive value |
| tx_dm_o | output | 1 | D- drive value |
| tx_oe_o | output | 1 | Line drive enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select (0 control, 1 flag) |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request to the processor |
| xcvr_susp_o | output | 1 | Transceiver low-power control |

## Verification
The idle detector is driven with three patterns. The first is a silent bus, which pins down the window in which suspend is entered. The second is periodic valid keep-alives, which must hold suspend off indefinitely. The third is periodic SE0 pulses that are too short to count, which must not hold suspend off. Between them, these tell a correct length threshold apart from one that is too loose or is missing. The K-on-line stimulus is applied both while suspended and while not suspended, which shows that wake is gated by the suspend state. A long SE0 applied while remote wakeup is active shows that a bus reset overrides both firmware-owned bits.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    typedef enum logic [2:0] {
        DRV_IDLE,
        DRV_LEAD_J,
        DRV_K,
        DRV_EOP_SE0,
        DRV_EOP_J
    } drv_e;

    localparam logic ADDR_CTRL     = 1'b0;
    localparam logic ADDR_FLAG     = 1'b1;
    localparam int   CTRL_SUSP_BIT = 0;
    localparam int   CTRL_RSM_BIT  = 1;
    localparam int   FLAG_SUSP_BIT = 0;

    function automatic line_e decode_line(logic dp, logic dm);
        return line_e'({dp, dm});
    endfunction

endpackage

// File: rtl/usb_susp_tick.sv
module usb_susp_tick #(
    parameter int CLK_PER_MS = 50000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = $clog2(CLK_PER_MS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    assign tick_o = (st_q.cnt == CW'(CLK_PER_MS - 1));

    always_comb begin
        st_d = st_q;
        if (clr_i || tick_o) st_d.cnt = '0;
        else                 st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R1: millisecond ticks are isolated pulses
    assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/usb_susp_linemon.sv
module usb_susp_linemon
    import usb_susp_pkg::*;
#(
    parameter int KA_MIN_CLKS = 66,
    parameter int RESET_CLKS  = 125
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  dp_i,
    input  logic  dm_i,
    output line_e line_o,
    output logic  keepalive_o,
    output logic  jk_edge_o,
    output logic  bus_rst_o
);
    localparam int SAT = RESET_CLKS + 1;
    localparam int SW  = $clog2(SAT + 1);

    typedef struct packed {
        line_e         prev;
        logic [SW-1:0] se0_cnt;
    } mon_st_t;

    mon_st_t st_d, st_q;

    assign line_o      = decode_line(dp_i, dm_i);
    assign keepalive_o = (line_o == LS_J) && (st_q.prev == LS_SE0)
                         && (st_q.se0_cnt >= SW'(KA_MIN_CLKS));
    assign jk_edge_o   = (st_q.prev == LS_J) && (line_o == LS_K);
    assign bus_rst_o   = (line_o == LS_SE0) && (st_q.se0_cnt == SW'(RESET_CLKS));

    always_comb begin
        st_d      = st_q;
        st_d.prev = line_o;
        if (line_o != LS_SE0)                st_d.se0_cnt = '0;
        else if (st_q.se0_cnt != SW'(SAT))   st_d.se0_cnt = st_q.se0_cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.prev    <= LS_J;
            st_q.se0_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: one reset pulse per long SE0
    assert_bus_rst_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rst_o |=> !bus_rst_o);

endmodule

// File: rtl/usb_susp_drive.sv
module usb_susp_drive
    import usb_susp_pkg::*;
#(
    parameter int CLK_PER_BIT = 33
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic dp_o,
    output logic dm_o,
    output logic oe_o
);
    localparam int CW      = $clog2(2 * CLK_PER_BIT + 1);
    localparam int ONE_BIT = CLK_PER_BIT - 1;
    localparam int TWO_BIT = 2 * CLK_PER_BIT - 1;

    typedef struct packed {
        drv_e          st;
        logic [CW-1:0] cnt;
    } drv_st_t;

    drv_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
        unique case (st_q.st)
            DRV_IDLE: begin
                st_d.cnt = '0;
                if (req_i) st_d.st = DRV_LEAD_J;
            end
            DRV_LEAD_J: begin
                if (st_q.cnt == CW'(ONE_BIT)) begin
                    st_d.st  = DRV_K;
                    st_d.cnt = '0;
                end
            end
            DRV_K: begin
                st_d.cnt = '0;
                if (!req_i) st_d.st = DRV_EOP_SE0;
            end
            DRV_EOP_SE0: begin
                if (st_q.cnt == CW'(TWO_BIT)) begin
                    st_d.st  = DRV_EOP_J;
                    st_d.cnt = '0;
                end
            end
            DRV_EOP_J: begin
                if (st_q.cnt == CW'(ONE_BIT)) begin
                    st_d.st  = DRV_IDLE;
                    st_d.cnt = '0;
                end
            end
            default: st_d = '{st: DRV_IDLE, cnt: '0};
        endcase
    end

    always_comb begin
        oe_o = (st_q.st != DRV_IDLE);
        unique case (st_q.st)
            DRV_K:       {dp_o, dm_o} = LS_K;
            DRV_EOP_SE0: {dp_o, dm_o} = LS_SE0;
            default:     {dp_o, dm_o} = LS_J;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{st: DRV_IDLE, cnt: '0};
        else         st_q <= st_d;
    end

    // R7: drive only starts on a firmware request
    assert_oe_needs_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(oe_o) |-> $past(req_i));
    // R8: the line is released only after J was driven
    assert_release_after_j_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(oe_o) |-> $past(!dp_o && dm_o));

endmodule

// File: rtl/usb_susp_ctl.sv
module usb_susp_ctl
    import usb_susp_pkg::*;
#(
    parameter int CLK_PER_BIT = 33,
    parameter int CLK_PER_MS  = 50000,
    parameter int IDLE_MS     = 3,
    parameter int RESET_CLKS  = 125,
    parameter int DATA_W      = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rx_dp_i,
    input  logic              rx_dm_i,
    output logic              tx_dp_o,
    output logic              tx_dm_o,
    output logic              tx_oe_o,
    input  logic              reg_we_i,
    input  logic              reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              wake_o,
    output logic              xcvr_susp_o
);
    localparam int KA_MIN_CLKS = 2 * CLK_PER_BIT;
    localparam int IW          = $clog2(IDLE_MS + 1);

    typedef struct packed {
        logic          susp;
        logic          rsm;
        logic          irqf;
        logic          wake;
        logic [IW-1:0] idle;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    tick, idle_clr, keepalive, jk_edge, bus_rst;
    logic    wr_ctrl, wr_flag;
    line_e   line;

    usb_susp_tick #(.CLK_PER_MS(CLK_PER_MS)) tick_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (idle_clr),
        .tick_o (tick)
    );

    usb_susp_linemon #(.KA_MIN_CLKS(KA_MIN_CLKS), .RESET_CLKS(RESET_CLKS)) mon_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .dp_i        (rx_dp_i),
        .dm_i        (rx_dm_i),
        .line_o      (line),
        .keepalive_o (keepalive),
        .jk_edge_o   (jk_edge),
        .bus_rst_o   (bus_rst)
    );

    usb_susp_drive #(.CLK_PER_BIT(CLK_PER_BIT)) drv_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (st_q.rsm),
        .dp_o   (tx_dp_o),
        .dm_o   (tx_dm_o),
        .oe_o   (tx_oe_o)
    );

    assign wr_ctrl = reg_we_i && (reg_addr_i == ADDR_CTRL);
    assign wr_flag = reg_we_i && (reg_addr_i == ADDR_FLAG);

    always_comb begin
        st_d     = st_q;
        idle_clr = 1'b0;
        // idle timing, frozen while suspended
        if (!st_q.susp && tick && !keepalive) begin
            if (st_q.idle == IW'(IDLE_MS)) begin
                st_d.susp = 1'b1;
                st_d.irqf = 1'b1;
                st_d.idle = '0;
            end else begin
                st_d.idle = st_q.idle + 1'b1;
            end
        end
        // firmware writes
        if (wr_ctrl) begin
            st_d.rsm = reg_wdata_i[CTRL_RSM_BIT];
            if (!reg_wdata_i[CTRL_SUSP_BIT] && st_q.susp) begin
                st_d.susp = 1'b0;
                idle_clr  = 1'b1;
            end
        end
        if (wr_flag && reg_wdata_i[FLAG_SUSP_BIT] && !(st_d.irqf && !st_q.irqf)) begin
            st_d.irqf = 1'b0;
        end
        if (keepalive) idle_clr = 1'b1;
        if (st_q.susp && jk_edge) st_d.wake = 1'b1;
        // bus reset overrides firmware state
        if (bus_rst) begin
            st_d.susp = 1'b0;
            st_d.rsm  = 1'b0;
            idle_clr  = 1'b1;
        end
        if (idle_clr) st_d.idle = '0;
        if (!st_d.susp) st_d.wake = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o       = st_q.irqf;
    assign xcvr_susp_o = st_q.susp;
    assign wake_o      = st_q.wake | (st_q.susp & (line == LS_K));

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_CTRL) begin
            reg_rdata_o[CTRL_SUSP_BIT] = st_q.susp;
            reg_rdata_o[CTRL_RSM_BIT]  = st_q.rsm;
        end else begin
            reg_rdata_o[FLAG_SUSP_BIT] = st_q.irqf;
        end
    end

    // R1: idle count never passes its limit
    assert_idle_bounded_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.idle <= IW'(IDLE_MS));
    // R1: suspend only begins on a millisecond tick
    assert_susp_on_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.susp) |-> $past(tick));
    // R3: the flag is raised with suspend entry
    assert_flag_on_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.susp) |-> irq_o);
    // R5: suspend never clears by itself
    assert_no_self_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.susp) |-> $past(bus_rst || (wr_ctrl && !reg_wdata_i[CTRL_SUSP_BIT])));
    // R6: a latched wake implies suspend
    assert_wake_needs_susp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.wake |-> st_q.susp);

endmodule

// File: tb/usb_susp_ctl_tb.sv
module usb_susp_ctl_tb_top;
    localparam int CPB  = 33;
    localparam int MS   = 200;
    localparam int RSTC = 125;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dp = 1'b0, dm = 1'b1;
    logic       tx_dp, tx_dm, tx_oe;
    logic       we = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, wake, xsusp;
    int         n_checks = 0;
    int         n_errors = 0;

    always #10 clk = ~clk;

    usb_susp_ctl #(.CLK_PER_BIT(CPB), .CLK_PER_MS(MS), .IDLE_MS(3),
                   .RESET_CLKS(RSTC), .DATA_W(8)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .rx_dp_i(dp), .rx_dm_i(dm),
        .tx_dp_o(tx_dp), .tx_dm_o(tx_dm), .tx_oe_o(tx_oe),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_o(irq), .wake_o(wake), .xcvr_susp_o(xsusp));

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic line_j();  dp = 1'b0; dm = 1'b1; endtask
    task automatic line_k();  dp = 1'b1; dm = 1'b0; endtask
    task automatic line_se0(); dp = 1'b0; dm = 1'b0; endtask

    task automatic pulse_se0(input int n);
        @(negedge clk); line_se0();
        cyc(n);
        line_j();
    endtask

    task automatic t_reset();
        logic [7:0] r;
        rd(1'b0, r); check("R5 reset ctrl", r, 0);
        rd(1'b1, r); check("R3 reset flag", r, 0);
        check("R4 reset xcvr", xsusp, 0);
        check("R6 reset wake", wake, 0);
        check("R7 reset oe", tx_oe, 0);
    endtask

    task automatic t_idle_entry();
        logic [7:0] r;
        cyc(MS * 7 / 2);
        check("R1 not yet suspended at 3.5ms", xsusp, 0);
        cyc(MS);
        rd(1'b0, r); check("R1 suspended by 4.5ms", r[0], 1);
        check("R4 xcvr follows", xsusp, 1);
        check("R3 irq on entry", irq, 1);
    endtask

    task automatic t_flag_w1c();
        logic [7:0] r;
        wr(1'b1, 8'h00); cyc(1);
        check("R3 write 0 ignored", irq, 1);
        wr(1'b1, 8'h01); cyc(1);
        check("R3 write 1 clears", irq, 0);
        rd(1'b0, r); check("R3 suspend kept", r[0], 1);
    endtask

    task automatic t_wake();
        @(negedge clk); line_k();
        #2 check("R6 wake immediate on K", wake, 1);
        cyc(3); line_j(); cyc(5);
        check("R6 wake held", wake, 1);
        wr(1'b0, 8'h00); cyc(1);
        check("R6 wake cleared with suspend", wake, 0);
        check("R4 xcvr low after clear", xsusp, 0);
        @(negedge clk); line_k();
        #2 check("R6 no wake when not suspended", wake, 0);
        cyc(3); line_j(); cyc(2);
        check("R6 still no wake", wake, 0);
    endtask

    task automatic t_no_fw_set();
        logic [7:0] r;
        wr(1'b0, 8'h01); cyc(1);
        rd(1'b0, r); check("R5 write 1 does not suspend", r[0], 0);
    endtask

    task automatic t_keepalive();
        for (int i = 0; i < 4; i++) begin
            pulse_se0(2 * CPB);
            cyc(2 * MS);
        end
        check("R2 keep-alives hold off suspend", xsusp, 0);
        pulse_se0(2 * CPB);
        cyc(2 * MS);
        pulse_se0(CPB);
        cyc(MS * 3 / 2 - CPB);
        check("R2 short SE0 no suspend yet", xsusp, 0);
        pulse_se0(CPB);
        cyc(MS);
        check("R2 short SE0 does not restart idle", xsusp, 1);
    endtask

    task automatic t_remote_wake();
        wr(1'b0, 8'h03);
        cyc(1);
        check("R7 oe up", tx_oe, 1);
        check("R7 lead J", {tx_dp, tx_dm}, 1);
        cyc(40);
        check("R7 K driven", {tx_dp, tx_dm}, 2);
        cyc(300);
        check("R7 K held", {tx_dp, tx_dm}, 2);
        check("R7 oe held", tx_oe, 1);
        check("R6 own drive does not wake", wake, 0);
        wr(1'b0, 8'h01);
        cyc(10);
        check("R8 EOP SE0", {tx_oe, tx_dp, tx_dm}, 4);
        cyc(70);
        check("R8 EOP J", {tx_oe, tx_dp, tx_dm}, 5);
        cyc(30);
        check("R8 released", tx_oe, 0);
        check("R5 suspend kept through resume", xsusp, 1);
    endtask

    task automatic t_bus_reset();
        logic [7:0] r;
        wr(1'b0, 8'h03);
        cyc(50);
        @(negedge clk); line_se0();
        cyc(RSTC + 10);
        rd(1'b0, r);
        check("R9 suspend cleared", r[0], 0);
        check("R9 send-resume cleared", r[1], 0);
        line_j();
        cyc(MS * 7 / 2);
        check("R9 idle time restarted", xsusp, 0);
        cyc(MS);
        check("R1 suspends again", xsusp, 1);
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        t_reset();
        t_idle_entry();
        t_flag_w1c();
        t_wake();
        t_no_fw_set();
        t_keepalive();
        t_remote_wake();
        t_bus_reset();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule